// File: doc/BRIEF.md
# Indirect Register Access Controller

This block gives a host a small window of six 16-bit locations through which it reaches a larger bank of wide internal registers. The host first stages up to four data words. It then writes an address word, and that write starts one internal transaction. The transaction reads or writes the internal register that the address names. A write moves all four staged words into the target register in a single step. A read returns one 16-bit word of the target, chosen by a word index in the address, into data location 0. To fetch a wide register the host runs one read transaction per word.

A status location reports whether a transaction is still running and whether an address write was dropped because the engine was busy. It also holds two host-writable active-low reset controls, which leave the block as output pins. Behind the engine sits a modelled register file: a set of DMA port units, a set of rate-generator units, one timer unit and one global DMA control unit.

Top module: `ixr_ctrl`

## Requirements
- R1: After reset, every window location reads 0x0000, and both reset outputs `glob_rst_n_o` and `codec_rst_n_o` are low.
- R2: Window select codes are: 0 status, 1 address, 2 to 5 data words 0 to 3. Codes 6 and 7 read 0x0000, and writes to them have no effect.
- R3: Only a host write to the address location (select 1) starts a transaction. Writes to the data or status locations leave the busy flag (status bit 0) at 0.
- R4: An accepted address write sets status bit 0 to 1 for exactly LAT cycles (default 4), starting with the cycle after the write. The address location then reads back the accepted address word.
- R5: Address word fields are: bits 15:12 unit type, bits 11:8 instance, bit 7 direction (1 read, 0 write), bits 3:2 parameter and bits 1:0 word index. Bits 6:4 are ignored. Type codes are 1 DMA port, 2 rate generator, 3 timer and 9 global DMA control.
- R6: Implemented registers are 64 bits wide. They are: type 1 with instances 1..N_PORT (default 6) and parameters 1 and 2; type 2 with instances 1..N_GEN (default 3) and parameters 1 and 2; type 3 with instance 1 and parameter 1; and type 9 with instance 1 and parameters 0 to 3.
- R7: A write transaction stores data word k into bits 16k+15:16k of the target. The words are the ones held at the moment the address was written; data writes during the transaction do not alter what is stored.
- R8: A read transaction places word `index` of the target into data location 0 when it completes. Data locations 1 to 3 are left unchanged.
- R9: An address that matches no implemented register still runs its full LAT cycles. A read of it returns 0x0000, and a write to it changes no register.
- R10: An address write while busy is ignored: no transaction starts and the address location keeps its value. It also sets the sticky error flag, status bit 5.
- R11: A status write sets `glob_rst_n_o` from bit 3 and `codec_rst_n_o` from bit 4, and both bits read back. Writing 1 to bit 5 clears the error flag. Bit 0 cannot be written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Host write strobe, one cycle per write |
| bus_sel | input | 3 | Window location select |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data of the selected location (combinational) |
| glob_rst_n_o | output | 1 | Global active-low reset control from status bit 3 |
| codec_rst_n_o | output | 1 | Codec-side active-low reset control from status bit 4 |

## Verification
The hardest case to reach is an address write that lands while an earlier transaction is still running, because its effects are all negative: no access happens and the address does not change. To reach it, the stimulus issues two address writes to different, already-filled registers two cycles apart. It then reads back both targets through fresh read transactions, which shows that only the first one was written, and checks the sticky flag and the held address. A separate sequence rewrites data word 0 in the middle of a write transaction to show that the transaction used the data staged at the moment the address was written.

// File: rtl/ixr_pkg.sv
package ixr_pkg;

  localparam int NWORDS = 4;

  // window select codes
  localparam logic [2:0] SEL_STAT = 3'd0;
  localparam logic [2:0] SEL_ADDR = 3'd1;
  localparam logic [2:0] SEL_D0   = 3'd2;

  // status bit positions
  localparam int ST_BUSY = 0;
  localparam int ST_GRST = 3;
  localparam int ST_CRST = 4;
  localparam int ST_ERR  = 5;

  // unit type codes
  localparam logic [3:0] UT_PORT   = 4'd1;
  localparam logic [3:0] UT_RATE   = 4'd2;
  localparam logic [3:0] UT_TIMER  = 4'd3;
  localparam logic [3:0] UT_GLOBAL = 4'd9;

  typedef struct packed {
    logic [3:0] utype;
    logic [3:0] inst;
    logic       rd;
    logic [2:0] spare;
    logic [1:0] param;
    logic [1:0] widx;
  } xaddr_t;

  typedef struct packed {
    logic       hit;
    logic [7:0] slot;
  } slot_t;

  function automatic int slot_count(input int n_port, input int n_gen);
    return 2 * n_port + 2 * n_gen + 5;
  endfunction

  // maps an address to a storage slot; ports first, then rate units,
  // then the timer, then the four global words
  function automatic slot_t map_slot(input xaddr_t a, input int n_port, input int n_gen);
    slot_t r;
    int    ins;
    int    pm;
    ins = int'(a.inst);
    pm  = int'(a.param);
    r   = '0;
    case (a.utype)
      UT_PORT: begin
        if (ins >= 1 && ins <= n_port && (pm == 1 || pm == 2)) begin
          r.hit  = 1'b1;
          r.slot = 8'((ins - 1) * 2 + pm - 1);
        end
      end
      UT_RATE: begin
        if (ins >= 1 && ins <= n_gen && (pm == 1 || pm == 2)) begin
          r.hit  = 1'b1;
          r.slot = 8'(2 * n_port + (ins - 1) * 2 + pm - 1);
        end
      end
      UT_TIMER: begin
        if (ins == 1 && pm == 1) begin
          r.hit  = 1'b1;
          r.slot = 8'(2 * n_port + 2 * n_gen);
        end
      end
      UT_GLOBAL: begin
        if (ins == 1) begin
          r.hit  = 1'b1;
          r.slot = 8'(2 * n_port + 2 * n_gen + 1 + pm);
        end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/ixr_seq.sv
module ixr_seq #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic busy,
  output logic accept,
  output logic collide,
  output logic done
);
  localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  logic [CW-1:0] cnt;

  assign accept  = trig && !busy;
  assign collide = trig && busy;
  assign done    = busy && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= CW'(LAT - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/ixr_window.sv
module ixr_window
  import ixr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic [2:0]           bus_sel,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic                 busy,
  input  logic                 accept,
  input  logic                 collide,
  input  logic                 rd_done,
  input  logic [DW-1:0]        rd_word,
  output logic [NWORDS*DW-1:0] stage,
  output logic [DW-1:0]        addr_q,
  output logic [DW-1:0]        data0,
  output logic                 err,
  output logic                 grst_n,
  output logic                 crst_n
);
  logic [DW-1:0] dreg [NWORDS];
  logic          stat_wr;

  assign stat_wr = bus_wr && (bus_sel == SEL_STAT);
  assign data0   = dreg[0];

  for (genvar k = 0; k < NWORDS; k++) begin : g_data
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  dreg[k] <= '0;
      else if (k == 0 && rd_done)                  dreg[k] <= rd_word;
      else if (bus_wr && bus_sel == 3'(SEL_D0 + k)) dreg[k] <= bus_wdata;
    end
    assign stage[k*DW +: DW] = dreg[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      err    <= 1'b0;
      grst_n <= 1'b0;
      crst_n <= 1'b0;
    end else begin
      if (accept) addr_q <= bus_wdata;
      if (collide)                        err <= 1'b1;
      else if (stat_wr && bus_wdata[ST_ERR]) err <= 1'b0;
      if (stat_wr) begin
        grst_n <= bus_wdata[ST_GRST];
        crst_n <= bus_wdata[ST_CRST];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel == SEL_STAT) begin
      bus_rdata[ST_BUSY] = busy;
      bus_rdata[ST_GRST] = grst_n;
      bus_rdata[ST_CRST] = crst_n;
      bus_rdata[ST_ERR]  = err;
    end else if (bus_sel == SEL_ADDR) begin
      bus_rdata = addr_q;
    end else begin
      for (int k = 0; k < NWORDS; k++)
        if (bus_sel == 3'(SEL_D0 + k)) bus_rdata = dreg[k];
    end
  end
endmodule

// File: rtl/ixr_regbank.sv
module ixr_regbank
  import ixr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int N_PORT = 6,
  parameter int N_GEN  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 accept,
  input  logic [DW-1:0]        new_addr,
  input  logic [NWORDS*DW-1:0] stage,
  input  logic                 done,
  output logic [DW-1:0]        rd_word,
  output logic                 hit,
  output logic                 is_rd
);
  localparam int NSLOT = slot_count(N_PORT, N_GEN);
  localparam int RW    = NWORDS * DW;

  xaddr_t        pend;
  logic [RW-1:0] pend_data;
  logic [RW-1:0] mem [NSLOT];
  slot_t         lk;

  assign lk    = map_slot(pend, N_PORT, N_GEN);
  assign hit   = lk.hit;
  assign is_rd = pend.rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      pend_data <= '0;
    end else if (accept) begin
      pend      <= xaddr_t'(new_addr);
      pend_data <= stage;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOT; s++) mem[s] <= '0;
    end else if (done && !pend.rd && lk.hit) begin
      for (int s = 0; s < NSLOT; s++)
        if (lk.slot == 8'(s)) mem[s] <= pend_data;
    end
  end

  always_comb begin
    rd_word = '0;
    for (int s = 0; s < NSLOT; s++)
      if (lk.hit && lk.slot == 8'(s)) rd_word = mem[s][int'(pend.widx)*DW +: DW];
  end
endmodule

// File: rtl/ixr_ctrl.sv
module ixr_ctrl
  import ixr_pkg::*;
#(
  parameter int DW     = 16,
  parameter int LAT    = 4,
  parameter int N_PORT = 6,
  parameter int N_GEN  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_sel,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          glob_rst_n_o,
  output logic          codec_rst_n_o
);
  // named internal events
  logic                 trig;
  logic                 busy;
  logic                 accept;
  logic                 collide;
  logic                 done;
  logic                 done_rd;
  logic                 hit;
  logic                 is_rd;
  logic                 err;
  logic [DW-1:0]        rd_word;
  logic [DW-1:0]        addr_q;
  logic [DW-1:0]        data0;
  logic [NWORDS*DW-1:0] stage;

  assign trig    = bus_wr && (bus_sel == SEL_ADDR);
  assign done_rd = done && is_rd;

  ixr_seq #(.LAT(LAT)) seq_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .busy(busy),
    .accept(accept), .collide(collide), .done(done)
  );

  ixr_window #(.DW(DW)) win_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .accept(accept), .collide(collide), .rd_done(done_rd),
    .rd_word(rd_word), .stage(stage), .addr_q(addr_q), .data0(data0),
    .err(err), .grst_n(glob_rst_n_o), .crst_n(codec_rst_n_o)
  );

  ixr_regbank #(.DW(DW), .N_PORT(N_PORT), .N_GEN(N_GEN)) bank_i (
    .clk(clk), .rst_n(rst_n), .accept(accept), .new_addr(bus_wdata),
    .stage(stage), .done(done), .rd_word(rd_word), .hit(hit), .is_rd(is_rd)
  );
endmodule

// File: rtl/ixr_ctrl_sva.sv
module ixr_ctrl_sva #(
  parameter int DW  = 16,
  parameter int LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_wr,
  input logic [2:0]    bus_sel,
  input logic [DW-1:0] bus_wdata,
  input logic          busy,
  input logic          err,
  input logic          done_rd,
  input logic          hit,
  input logic [DW-1:0] addr_q,
  input logic [DW-1:0] data0
);
  logic [15:0] blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    blen <= '0;
    else if (busy) blen <= blen + 1'b1;
    else           blen <= '0;
  end

  // R3: busy only rises after an address write
  a_r3_trigger_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bus_wr && bus_sel == 3'd1));

  // R4: an idle address write raises busy
  a_r4_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd1 && !busy) |=> busy);

  // R4: busy lasts exactly LAT cycles
  a_r4_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == 16'(LAT)));

  // R9: unmatched read returns zero
  a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done_rd && !hit) |=> (data0 == '0));

  // R10: write while busy flags the error and keeps the address
  a_r10_collide_err: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd1 && busy) |=> (err && $stable(addr_q)));

  // R11: write-one clears the error flag
  a_r11_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 3'd0 && bus_wdata[5]) |=> !err);
endmodule

bind ixr_ctrl ixr_ctrl_sva #(.DW(DW), .LAT(LAT)) sva_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .busy(busy), .err(err), .done_rd(done_rd),
  .hit(hit), .addr_q(addr_q), .data0(data0)
);

// File: tb/ixr_ctrl_tb_top.sv
module ixr_ctrl_tb_top;
  localparam int LAT = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_sel = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        glob_rst_n_o;
  logic        codec_rst_n_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  ixr_ctrl #(.LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .glob_rst_n_o(glob_rst_n_o), .codec_rst_n_o(codec_rst_n_o)
  );

  // targets: six implemented, two not (instance 7 of type 1, type 5)
  localparam logic [15:0] T_ADDR [8] = '{16'h1104, 16'h1208, 16'h2104, 16'h2208,
                                          16'h3104, 16'h910C, 16'h1704, 16'h5104};
  localparam logic        T_HIT  [8] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};

  function automatic logic [15:0] pat(input logic [15:0] a, input int k);
    return a ^ (16'h1111 * 16'(k)) ^ 16'h5A3C;
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] s, input logic [15:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] s, output logic [15:0] d);
    bus_sel = s;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (LAT + 1) @(negedge clk);
  endtask

  task automatic stage4(input logic [15:0] a);
    for (int k = 0; k < 4; k++) bus_write(3'(2 + k), pat(a, k));
  endtask

  task automatic read_word(input logic [15:0] a, input int k, output logic [15:0] d);
    bus_write(3'd1, a | 16'h0080 | 16'(k));
    settle();
    bus_read(3'd2, d);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state, R2 unused select codes
    for (int s = 0; s < 8; s++) begin
      bus_read(3'(s), v);
      check((s > 5) ? "R2 spare select reads zero" : "R1 reset value", v, 16'h0000);
    end
    check("R1 global reset output", 16'(glob_rst_n_o), 16'h0000);
    check("R1 codec reset output", 16'(codec_rst_n_o), 16'h0000);

    // R3 data write starts nothing
    bus_write(3'd2, 16'hBEEF);
    bus_read(3'd0, v);
    check("R3 data write leaves busy clear", v, 16'h0000);

    // R4 busy window length and address readback
    bus_write(3'd1, 16'h1100);
    bus_read(3'd0, v);
    check("R4 busy set after address write", v & 16'h0001, 16'h0001);
    repeat (LAT - 1) @(negedge clk);
    bus_read(3'd0, v);
    check("R4 busy held through last cycle", v & 16'h0001, 16'h0001);
    @(negedge clk);
    bus_read(3'd0, v);
    check("R4 busy clear after LAT cycles", v & 16'h0001, 16'h0000);
    bus_read(3'd1, v);
    check("R4 address readback", v, 16'h1100);

    // R5 R6 R7 R8 R9: table walk, write then read each word
    for (int i = 0; i < 8; i++) begin
      stage4(T_ADDR[i]);
      bus_write(3'd1, T_ADDR[i]);
      settle();
      for (int k = 0; k < 4; k++) begin
        read_word(T_ADDR[i], k, v);
        check(T_HIT[i] ? "R7 R8 word readback" : "R9 unmatched reads zero",
              v, T_HIT[i] ? pat(T_ADDR[i], k) : 16'h0000);
      end
    end

    // R5 reserved bits 6:4 ignored in decode
    read_word(16'h1174, 1, v);
    check("R5 spare address bits ignored", v, pat(16'h1104, 1));

    // R8 data words 1..3 untouched by a read
    bus_write(3'd3, 16'h7777);
    read_word(16'h1104, 2, v);
    bus_read(3'd3, v);
    check("R8 data word 1 kept across read", v, 16'h7777);

    // R10 address write while busy
    stage4(16'hC0DE);
    bus_write(3'd1, 16'h2104);
    bus_write(3'd1, 16'h2208);
    bus_read(3'd0, v);
    check("R10 sticky error set", v & 16'h0020, 16'h0020);
    bus_read(3'd1, v);
    check("R10 address held on ignored write", v, 16'h2104);
    settle();
    read_word(16'h2208, 0, v);
    check("R10 ignored write did not reach target", v, pat(16'h2208, 0));
    read_word(16'h2104, 3, v);
    check("R10 accepted write landed", v, pat(16'hC0DE, 3));

    // R11 reset controls and error clear
    bus_write(3'd0, 16'h0018);
    check("R11 global reset output high", 16'(glob_rst_n_o), 16'h0001);
    check("R11 codec reset output high", 16'(codec_rst_n_o), 16'h0001);
    bus_read(3'd0, v);
    check("R11 status readback with error", v, 16'h0038);
    bus_write(3'd0, 16'h0031);
    bus_read(3'd0, v);
    check("R11 error cleared, bit0 not writable", v, 16'h0010);
    check("R11 global reset output low", 16'(glob_rst_n_o), 16'h0000);

    // R7 snapshot: data rewritten mid-transaction
    stage4(16'hA1B2);
    bus_write(3'd1, 16'h9100);
    bus_write(3'd2, 16'hDEAD);
    settle();
    read_word(16'h9100, 0, v);
    check("R7 staged word used, not later write", v, pat(16'hA1B2, 0));

    // R2 write to spare select changes nothing
    bus_write(3'd7, 16'hFFFF);
    bus_read(3'd0, v);
    check("R2 spare write leaves status", v, 16'h0010);
    bus_read(3'd1, v);
    check("R2 spare write leaves address", v, 16'h9180);
    bus_read(3'd7, v);
    check("R2 spare select still reads zero", v, 16'h0000);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule